// File: doc/BRIEF.md
# Wake-on-Radio Duty-Cycle Controller

This block polls an external receiver on a fixed schedule so that a host processor can stay asleep. A phase counter advances on single-cycle strobes derived from a slow (about 32 kHz) low-power clock. When the configured sleep period has elapsed, the controller raises a receiver-enable, waits a fixed settle time, and then opens a listen window of programmable length. If the demodulator flags a valid packet inside that window, the controller holds the receiver on until a packet-done input arrives. It also captures the slow-tick timestamp of that message so that the host can resynchronise its timers. If no valid packet is flagged, the controller goes back to sleep.

The controller counts wake-ups. After a programmable number of them, it asks for a calibration of the slow oscillator against the fast reference clock, using a request/acknowledge handshake. A calibration only starts from the sleep state. A request that falls due while the receiver is busy is therefore held until the controller is idle again. A synchronous enable input stops the block: while it is low, every counter and flag is cleared and the controller sits in sleep.

The five states, with their `fsm_state` codes, are SLEEP = 0, WAKE_SETTLE = 1, LISTEN = 2, RX_HOLD = 3 and CAL = 4. The transitions are:

- sleep-expire: SLEEP to WAKE_SETTLE.
- cal-start: SLEEP to CAL.
- settle-done: WAKE_SETTLE to LISTEN.
- packet-hit: LISTEN to RX_HOLD.
- window-close: LISTEN to SLEEP.
- packet-end: RX_HOLD to SLEEP.
- cal-done: CAL to SLEEP.
- disable: any state to SLEEP.

Top module: `wor_duty_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the clock edge after any cycle in which `enable` is low, the outputs are cleared:
  - `fsm_state` is 0 (SLEEP).
  - `rx_en` and `cal_req` are 0.
  - `ts_value`, `ts_valid` and `ts_ovf` are 0.

  The same edge clears the phase counter, the wake-up counter, the calibration-pending flag and the timestamp counter.
- R2: In SLEEP with no calibration pending, the slow tick that completes `sleep_ticks` ticks in that state moves the block to WAKE_SETTLE. A value of 0 counts as 1. `rx_en` is 1 exactly in WAKE_SETTLE, LISTEN and RX_HOLD.
- R3: WAKE_SETTLE moves to LISTEN on the slow tick that completes `SETTLE_TICKS` ticks in that state.
- R4: In LISTEN, the slow tick that completes `listen_ticks` ticks (0 counts as 1) with no `pkt_valid` returns the block to SLEEP.
- R5: `pkt_valid` in LISTEN moves the block to RX_HOLD on the next edge, even if the window would expire in the same cycle. `pkt_valid` in any other state has no effect on state or timestamp.
- R6: RX_HOLD persists until `pkt_done` is seen, then goes to SLEEP.
- R7: A free-running timestamp counter of SW bits counts slow ticks since `enable` was last raised. When a packet-hit occurs while no timestamp is held, `ts_value` becomes that counter's value before the tick of that cycle, and `ts_valid` becomes 1.
- R8: A packet-hit while `ts_valid` is 1 and `ts_read` is 0 leaves `ts_value` unchanged and sets the sticky `ts_ovf`. `ts_read` clears `ts_valid` and `ts_ovf`. A read and a packet-hit in the same cycle load the new value with `ts_valid` = 1 and `ts_ovf` = 0.
- R9: Each sleep-expire counts one wake-up. When the count reaches `cal_every`, a calibration becomes pending and the count restarts. A `cal_every` of 0 disables calibration. A pending calibration in SLEEP moves the block to CAL on the next edge, ahead of sleep counting. `cal_req` is 1 only in CAL.
- R10: A pending calibration is never taken from WAKE_SETTLE, LISTEN or RX_HOLD; it waits for SLEEP. CAL persists until `cal_ack`, then returns to SLEEP with the sleep count restarted from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Synchronous run enable; low clears and forces SLEEP |
| slow_tick | input | 1 | One-cycle strobe per slow-clock period |
| sleep_ticks | input | TW | Sleep period in slow ticks |
| listen_ticks | input | LW | Listen window in slow ticks |
| cal_every | input | CW | Wake-ups between calibrations, 0 disables |
| pkt_valid | input | 1 | Valid-packet indication from the demodulator |
| pkt_done | input | 1 | End of received packet |
| cal_ack | input | 1 | Calibration finished |
| ts_read | input | 1 | Host has read the timestamp |
| rx_en | output | 1 | Receiver enable |
| cal_req | output | 1 | Calibration request |
| fsm_state | output | 3 | Current state code |
| ts_value | output | SW | Captured timestamp |
| ts_valid | output | 1 | A timestamp is held |
| ts_ovf | output | 1 | Sticky: a message was missed before the read |

## Verification
The bench builds the block with a few narrow parameter values:

- TW = 4 and LW = 4, so random sleep and listen lengths cover 0 to 15, including the 0-as-1 case.
- CW = 3, so calibration intervals of 0 to 7 recur many times in a short run.
- SW = 6, so the timestamp counter wraps every 64 ticks and wrapped captures are compared.
- SETTLE_TICKS = 2.

With these values, calibrations deferred behind long receptions, overflowing captures and read/capture collisions all occur often under random stimulus. A cycle model written from the requirements is compared with the outputs in every cycle.

// File: rtl/wor_pkg.sv
package wor_pkg;
    typedef enum logic [2:0] {
        ST_SLEEP  = 3'd0,
        ST_SETTLE = 3'd1,
        ST_LISTEN = 3'd2,
        ST_RXHOLD = 3'd3,
        ST_CAL    = 3'd4
    } wor_state_t;
endpackage

// File: rtl/wor_phase_cnt.sv
module wor_phase_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt;
    logic [W:0]   eff_lim;
    logic [W:0]   cnt_inc;

    always_comb begin
        eff_lim = (limit == '0) ? (W+1)'(1) : {1'b0, limit};
        cnt_inc = {1'b0, cnt} + (W+1)'(1);
        hit     = tick && (cnt_inc >= eff_lim);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (clr)   cnt <= '0;
        else if (tick)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/wor_cal_sched.sv
module wor_cal_sched #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          wake,
    input  logic          cal_done,
    input  logic [CW-1:0] every,
    output logic          pending
);
    logic [CW-1:0] wake_cnt;
    logic [CW:0]   wake_inc;

    assign wake_inc = {1'b0, wake_cnt} + (CW+1)'(1);

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            wake_cnt <= '0;
            pending  <= 1'b0;
        end else begin
            if (cal_done) pending <= 1'b0;
            if (wake && (every != '0)) begin
                if (wake_inc >= {1'b0, every}) begin
                    pending  <= 1'b1;
                    wake_cnt <= '0;
                end else begin
                    wake_cnt <= wake_cnt + 1'b1;
                end
            end
        end
    end

    // R10
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !en)
        pending && !cal_done |=> pending);
endmodule

// File: rtl/wor_stamp.sv
module wor_stamp #(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic          capture,
    input  logic          rd,
    output logic [SW-1:0] ts_value,
    output logic          ts_valid,
    output logic          ts_ovf
);
    logic [SW-1:0] stamp;

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            stamp    <= '0;
            ts_value <= '0;
            ts_valid <= 1'b0;
            ts_ovf   <= 1'b0;
        end else begin
            stamp <= stamp + SW'(tick);
            if (capture) begin
                if (!ts_valid || rd) begin
                    ts_value <= stamp;
                    ts_valid <= 1'b1;
                    ts_ovf   <= 1'b0;
                end else begin
                    ts_ovf <= 1'b1;
                end
            end else if (rd) begin
                ts_valid <= 1'b0;
                ts_ovf   <= 1'b0;
            end
        end
    end

    // R8
    ts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !en)
        ts_valid && !rd |=> $stable(ts_value));
    // R8
    ts_ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n || !en)
        capture && ts_valid && !rd |=> ts_ovf);
endmodule

// File: rtl/wor_duty_ctrl.sv
module wor_duty_ctrl
    import wor_pkg::*;
#(
    parameter int TW           = 16,
    parameter int LW           = 8,
    parameter int CW           = 8,
    parameter int SW           = 16,
    parameter int SETTLE_TICKS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          slow_tick,
    input  logic [TW-1:0] sleep_ticks,
    input  logic [LW-1:0] listen_ticks,
    input  logic [CW-1:0] cal_every,
    input  logic          pkt_valid,
    input  logic          pkt_done,
    input  logic          cal_ack,
    input  logic          ts_read,
    output logic          rx_en,
    output logic          cal_req,
    output logic [2:0]    fsm_state,
    output logic [SW-1:0] ts_value,
    output logic          ts_valid,
    output logic          ts_ovf
);
    localparam int CNTW = (TW > LW) ? TW : LW;

    wor_state_t      state, nxt;
    logic [CNTW-1:0] lim;
    logic            phase_hit;
    logic            wake;
    logic            capture;
    logic            cal_pend;
    logic            cal_done;

    always_comb begin
        unique case (state)
            ST_SLEEP:  lim = CNTW'(sleep_ticks);
            ST_SETTLE: lim = CNTW'(SETTLE_TICKS);
            ST_LISTEN: lim = CNTW'(listen_ticks);
            default:   lim = '0;
        endcase
    end

    wor_phase_cnt #(.W(CNTW)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!enable || (nxt != state)),
        .tick  (slow_tick),
        .limit (lim),
        .hit   (phase_hit)
    );

    always_comb begin
        nxt     = state;
        wake    = 1'b0;
        capture = 1'b0;
        unique case (state)
            ST_SLEEP: begin
                if (cal_pend) begin
                    nxt = ST_CAL;
                end else if (phase_hit) begin
                    nxt  = ST_SETTLE;
                    wake = 1'b1;
                end
            end
            ST_SETTLE: if (phase_hit) nxt = ST_LISTEN;
            ST_LISTEN: begin
                if (pkt_valid) begin
                    nxt     = ST_RXHOLD;
                    capture = 1'b1;
                end else if (phase_hit) begin
                    nxt = ST_SLEEP;
                end
            end
            ST_RXHOLD: if (pkt_done) nxt = ST_SLEEP;
            ST_CAL:    if (cal_ack)  nxt = ST_SLEEP;
            default:   nxt = ST_SLEEP;
        endcase
        if (!enable) begin
            nxt     = ST_SLEEP;
            wake    = 1'b0;
            capture = 1'b0;
        end
    end

    assign cal_done = enable && (state == ST_CAL) && cal_ack;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_SLEEP;
        else        state <= nxt;
    end

    always_comb begin
        rx_en     = (state == ST_SETTLE) || (state == ST_LISTEN) || (state == ST_RXHOLD);
        cal_req   = (state == ST_CAL);
        fsm_state = state;
    end

    wor_cal_sched #(.CW(CW)) u_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (enable),
        .wake     (wake),
        .cal_done (cal_done),
        .every    (cal_every),
        .pending  (cal_pend)
    );

    wor_stamp #(.SW(SW)) u_stamp (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (enable),
        .tick     (slow_tick),
        .capture  (capture),
        .rd       (ts_read),
        .ts_value (ts_value),
        .ts_valid (ts_valid),
        .ts_ovf   (ts_ovf)
    );

    // R1
    disable_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state == ST_SLEEP) && !rx_en && !ts_valid);
    // R5
    listen_to_rx_chk: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        (state == ST_LISTEN) && pkt_valid |=> (state == ST_RXHOLD));
    // R6
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        (state == ST_RXHOLD) && !pkt_done |=> (state == ST_RXHOLD));
    // R9
    cal_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_req) |-> ($past(state) == ST_SLEEP));
endmodule

// File: tb/wor_duty_ctrl_tb_top.sv
module wor_duty_ctrl_tb_top;
    localparam int TW = 4, LW = 4, CW = 3, SW = 6, SETTLE = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, slow_tick = 1'b0;
    logic [TW-1:0] sleep_ticks = '0;
    logic [LW-1:0] listen_ticks = '0;
    logic [CW-1:0] cal_every = '0;
    logic pkt_valid = 1'b0, pkt_done = 1'b0, cal_ack = 1'b0, ts_read = 1'b0;
    logic rx_en, cal_req, ts_valid, ts_ovf;
    logic [2:0] fsm_state;
    logic [SW-1:0] ts_value;

    int checks = 0, failures = 0, cycles = 0;
    int m_state = 0, m_cnt = 0, m_wake = 0, m_pend = 0, m_stamp = 0;
    int m_ts = 0, m_tv = 0, m_ovf = 0;

    always #4 clk = ~clk;

    wor_duty_ctrl #(.TW(TW), .LW(LW), .CW(CW), .SW(SW), .SETTLE_TICKS(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .slow_tick(slow_tick),
        .sleep_ticks(sleep_ticks), .listen_ticks(listen_ticks), .cal_every(cal_every),
        .pkt_valid(pkt_valid), .pkt_done(pkt_done), .cal_ack(cal_ack), .ts_read(ts_read),
        .rx_en(rx_en), .cal_req(cal_req), .fsm_state(fsm_state),
        .ts_value(ts_value), .ts_valid(ts_valid), .ts_ovf(ts_ovf)
    );

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int exp_rx(input int st);
        return (st == 1 || st == 2 || st == 3) ? 1 : 0;
    endfunction

    // reference model of the requirements, advanced at each edge
    always @(posedge clk) begin
        if (!rst_n || !enable) begin
            m_state = 0; m_cnt = 0; m_wake = 0; m_pend = 0;
            m_stamp = 0; m_ts = 0; m_tv = 0; m_ovf = 0;
        end else begin
            if (m_state == 2 && pkt_valid) begin
                if (!m_tv || ts_read) begin m_ts = m_stamp; m_tv = 1; m_ovf = 0; end
                else m_ovf = 1;
            end else if (ts_read) begin
                m_tv = 0; m_ovf = 0;
            end
            m_stamp = (m_stamp + int'(slow_tick)) % (1 << SW);
            case (m_state)
                0: if (m_pend) begin m_state = 4; m_cnt = 0; end
                   else if (slow_tick) begin
                       if (m_cnt + 1 >= eff(int'(sleep_ticks))) begin
                           m_state = 1; m_cnt = 0;
                           if (cal_every != 0) begin
                               if (m_wake + 1 >= int'(cal_every)) begin m_pend = 1; m_wake = 0; end
                               else m_wake++;
                           end
                       end else m_cnt++;
                   end
                1: if (slow_tick) begin
                       if (m_cnt + 1 >= SETTLE) begin m_state = 2; m_cnt = 0; end
                       else m_cnt++;
                   end
                2: if (pkt_valid) begin m_state = 3; m_cnt = 0; end
                   else if (slow_tick) begin
                       if (m_cnt + 1 >= eff(int'(listen_ticks))) begin m_state = 0; m_cnt = 0; end
                       else m_cnt++;
                   end
                3: if (pkt_done) begin m_state = 0; m_cnt = 0; end
                default: if (cal_ack) begin m_state = 0; m_cnt = 0; m_pend = 0; end
            endcase
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d at t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic string st_tag(input int st);
        case (st)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic cmp_model();
        chk(int'(fsm_state) == m_state, st_tag(m_state), int'(fsm_state), m_state);
        chk(int'(rx_en) == exp_rx(m_state), "R2 rx_en", int'(rx_en), exp_rx(m_state));
        chk(int'(cal_req) == (m_state == 4 ? 1 : 0), "R9 cal_req", int'(cal_req), (m_state == 4 ? 1 : 0));
        chk(int'(ts_valid) == m_tv, "R8 ts_valid", int'(ts_valid), m_tv);
        chk(int'(ts_ovf) == m_ovf, "R8 ts_ovf", int'(ts_ovf), m_ovf);
        if (m_tv != 0)
            chk(int'(ts_value) == m_ts, "R7 ts_value", int'(ts_value), m_ts);
    endtask

    task automatic cyc(input bit tk, input bit pv, input bit pd, input bit ack, input bit rd);
        slow_tick = tk; pkt_valid = pv; pkt_done = pd; cal_ack = ack; ts_read = rd;
        @(posedge clk);
        @(negedge clk);
        cmp_model();
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog act=%0d exp=0", cycles);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd24681));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(fsm_state == 3'd0 && !rx_en && !cal_req && !ts_valid && !ts_ovf, "R1 reset",
            int'(fsm_state), 0);
        rst_n = 1'b1;
        sleep_ticks = 4'd2; listen_ticks = 4'd1; cal_every = 3'd2; enable = 1'b1;
        cyc(1, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0);
        chk(fsm_state == 3'd1 && rx_en, "R2 sleep expire", int'(fsm_state), 1);
        cyc(1, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0);
        chk(fsm_state == 3'd2, "R3 settle done", int'(fsm_state), 2);
        cyc(1, 1, 0, 0, 0);
        chk(fsm_state == 3'd3, "R5 packet hit over expiry", int'(fsm_state), 3);
        chk(ts_valid && ts_value == 6'd4, "R7 timestamp", int'(ts_value), 4);
        cyc(0, 1, 0, 0, 0);
        chk(fsm_state == 3'd3 && !ts_ovf, "R5 pkt_valid ignored in RX_HOLD", int'(ts_ovf), 0);
        cyc(0, 0, 1, 0, 0);
        chk(fsm_state == 3'd0, "R6 packet end", int'(fsm_state), 0);
        repeat (4) cyc(1, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0);
        chk(fsm_state == 3'd0 && !rx_en, "R4 window close", int'(fsm_state), 0);
        cyc(0, 0, 0, 0, 0);
        chk(fsm_state == 3'd4 && cal_req, "R9 cal start", int'(fsm_state), 4);
        cyc(1, 0, 0, 0, 0);
        chk(fsm_state == 3'd4, "R10 cal waits for ack", int'(fsm_state), 4);
        cyc(0, 0, 0, 1, 0);
        chk(fsm_state == 3'd0 && !cal_req, "R10 cal done", int'(fsm_state), 0);
        repeat (4) cyc(1, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0);
        chk(ts_ovf && ts_value == 6'd4, "R8 overflow keeps value", int'(ts_value), 4);
        cyc(0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 1);
        chk(!ts_valid && !ts_ovf, "R8 read clears", int'(ts_valid), 0);
        cal_every = 3'd1;
        repeat (4) cyc(1, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0);
        repeat (3) cyc(1, 0, 0, 0, 0);
        chk(fsm_state == 3'd3 && !cal_req, "R10 deferred in RX_HOLD", int'(fsm_state), 3);
        cyc(0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 0);
        chk(fsm_state == 3'd4, "R10 deferred cal taken", int'(fsm_state), 4);
        enable = 1'b0;
        cyc(0, 0, 0, 0, 0);
        chk(fsm_state == 3'd0 && !ts_valid && !cal_req, "R1 disable", int'(fsm_state), 0);
        enable = 1'b1; cal_every = 3'd0; sleep_ticks = 4'd0;
        cyc(1, 0, 0, 0, 0);
        chk(fsm_state == 3'd1, "R2 zero sleep as one", int'(fsm_state), 1);
        cyc(0, 1, 0, 0, 0);
        chk(fsm_state == 3'd1 && !ts_valid, "R5 pkt_valid ignored in settle", int'(fsm_state), 1);

        for (int i = 0; i < 6000; i++) begin
            if (i % 400 == 0) begin
                sleep_ticks  = 4'($urandom_range(0, 15));
                listen_ticks = 4'($urandom_range(0, 15));
                cal_every    = 3'($urandom_range(0, 7));
            end
            enable = ($urandom_range(0, 299) != 0);
            cyc($urandom_range(0, 2) == 0, $urandom_range(0, 11) == 0,
                $urandom_range(0, 7) == 0, $urandom_range(0, 4) == 0,
                $urandom_range(0, 19) == 0);
        end
        finish_run();
    end
endmodule